// File: doc/BRIEF.md
# Two-Channel DMA Request Arbiter

This block decides, on every bus clock, who owns the bus: the CPU or one of two DMA channels. Each channel owns a single pending-request flag. A chosen edge on that channel's external request pin sets the flag. A per-channel select input chooses whether the rising or the falling edge counts. Pins are sampled once per clock, so edges on both pins in the same clock period set both flags together.

When the CPU holds the bus and a channel is both pending and enabled, the lower-numbered channel wins. Its flag drops on the same clock edge that hands it the bus, which is the moment its transfer starts. The channel keeps the bus until it pulses its transfer-done strobe, and the bus then returns to the CPU. After any DMA transfer the CPU must complete one access, shown by its access-done strobe, before another channel may be granted. This holds even when another channel is already waiting. Address generation, counting and the data movement itself happen elsewhere.

Top module: `dma_req_arbiter`

## Requirements
- R1: While reset is low at a clock edge, the next cycle shows the CPU grant at 1, both DMA grants at 0 and both pending flags at 0.
- R2: With `rise_sel_i[k]` = 1 a 0-to-1 change of `req_pin_i[k]` sets `req_pend_o[k]`; with `rise_sel_i[k]` = 0 a 1-to-0 change does. The opposite change leaves the flag at 0. The flag shows 1 in the cycle after the clock edge that first samples the new pin level.
- R3: Further selected edges while a flag is already 1 merge into it, and the channel is granted exactly once.
- R4: A flag can be set while `ch_en_i[k]` = 0, but channel k is never granted until its enable is 1. Once enabled and allowed, it is granted at the next clock edge.
- R5: When several channels are pending, enabled and allowed, the lowest-numbered one is granted first.
- R6: A pending flag stays at 1 until the clock edge at which its channel is granted, and reads 0 from that cycle on.
- R7: A granted channel keeps the bus until its `xfer_done_i` bit is 1 at a clock edge, and the CPU owns the bus in the next cycle.
- R8: After a DMA transfer ends, no channel is granted until `cpu_done_i` is 1 at a clock edge while the CPU owns the bus. A waiting channel is granted at that same edge.
- R9: Selected edges on both pins in the same clock period set both flags in the same cycle.
- R10: Exactly one of `grant_cpu_o` and the bits of `grant_dma_o` is 1 in every cycle after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Synchronous active-low reset |
| req_pin_i | input | NCH | External request pins, one per channel |
| ch_en_i | input | NCH | Per-channel enable for granting |
| rise_sel_i | input | NCH | Edge select per channel: 1 = rising, 0 = falling |
| cpu_done_i | input | 1 | CPU finished one bus access |
| xfer_done_i | input | NCH | Channel k finished its transfer |
| grant_cpu_o | output | 1 | CPU owns the bus |
| grant_dma_o | output | NCH | Channel k owns the bus (one-hot with grant_cpu_o) |
| req_pend_o | output | NCH | Pending-request flags |

## Verification
The properties assume that a transfer-done bit is raised only by the channel that owns the bus, and that the CPU strobe is raised only while the CPU owns the bus. Strobes from anyone else are ignored by the design, but they would make the CPU-turn bookkeeping in the checker meaningless. The stimulus raises each done strobe only after it has observed the matching grant at the ports, and it lowers the strobe in the next cycle. The pins change only between clock edges, and every case starts from a reset taken with the pins already at their idle level, so no stray edge is seen.

// File: rtl/dmaarb_pkg.sv
// Shared types for the DMA request arbiter.
package dmaarb_pkg;
    // Kind of bus owner held by the ownership state machine.
    typedef enum logic {
        OWN_CPU = 1'b0,
        OWN_DMA = 1'b1
    } own_kind_e;
endpackage

// File: rtl/dmaarb_edge_flag.sv
// Per-channel request flag.
// Samples the pin once per clock. A selected edge sets the flag, and a
// start pulse clears it. An edge arriving with the start pulse wins, so a
// fresh request is not lost.
// Assumes: the pin is already synchronous to clk_i; during reset the pin
// level is captured so that no edge is seen on leaving reset.
module dmaarb_edge_flag (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic pin_i,
    input  logic rise_sel_i,
    input  logic start_i,
    output logic flag_o
);
    logic prev_q;
    logic flag_q;
    logic edge_hit;

    // Selected-edge detection against last sampled level.
    always_comb begin
        if (rise_sel_i) edge_hit = pin_i & ~prev_q;
        else            edge_hit = ~pin_i & prev_q;
    end

    // Pin history register.
    always_ff @(posedge clk_i) begin
        prev_q <= pin_i;
    end

    // Pending flag: set by edge, cleared at transfer start.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) flag_q <= 1'b0;
        else         flag_q <= (flag_q & ~start_i) | edge_hit;
    end

    assign flag_o = flag_q;
endmodule

// File: rtl/dmaarb_pick.sv
// Fixed-priority picker: the lowest index among the eligible channels wins.
// Assumes: nothing; purely combinational.
module dmaarb_pick #(
    parameter int NCH = 2,
    localparam int IW = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic [NCH-1:0] elig_i,
    output logic           any_o,
    output logic [IW-1:0]  idx_o,
    output logic [NCH-1:0] onehot_o
);
    // Scan from the top so the lowest set bit is written last.
    always_comb begin
        idx_o = '0;
        for (int i = NCH - 1; i >= 0; i--) begin
            if (elig_i[i]) idx_o = i[IW-1:0];
        end
    end

    assign onehot_o = elig_i & (~elig_i + 1'b1);
    assign any_o    = |elig_i;
endmodule

// File: rtl/dmaarb_owner_fsm.sv
// Bus-ownership state machine.
// The CPU owns the bus by default. A winning channel is started at the next
// edge. The bus returns to the CPU when the owner signals done, and the CPU
// must finish one access before any further channel start.
// Assumes: done strobes from non-owners may arrive and are ignored.
module dmaarb_owner_fsm
    import dmaarb_pkg::*;
#(
    parameter int NCH = 2,
    localparam int IW = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic           clk_i,
    input  logic           rst_ni,
    input  logic           any_i,
    input  logic [IW-1:0]  idx_i,
    input  logic [NCH-1:0] onehot_i,
    input  logic           cpu_done_i,
    input  logic [NCH-1:0] xfer_done_i,
    output logic [NCH-1:0] start_o,
    output logic           grant_cpu_o,
    output logic [NCH-1:0] grant_dma_o
);
    own_kind_e      kind_q, kind_d;
    logic [IW-1:0]  idx_q, idx_d;
    logic           owed_q, owed_d;
    logic           cpu_free;

    // CPU is free to yield once it owes nothing or completes its access now.
    assign cpu_free = !owed_q || cpu_done_i;

    // Next-owner decision and transfer-start pulse.
    always_comb begin
        kind_d  = kind_q;
        idx_d   = idx_q;
        owed_d  = owed_q;
        start_o = '0;
        if (kind_q == OWN_CPU) begin
            if (cpu_done_i) owed_d = 1'b0;
            if (any_i && cpu_free) begin
                kind_d  = OWN_DMA;
                idx_d   = idx_i;
                start_o = onehot_i;
            end
        end else begin
            if (xfer_done_i[idx_q]) begin
                kind_d = OWN_CPU;
                owed_d = 1'b1;
            end
        end
    end

    // Ownership registers.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            kind_q <= OWN_CPU;
            idx_q  <= '0;
            owed_q <= 1'b0;
        end else begin
            kind_q <= kind_d;
            idx_q  <= idx_d;
            owed_q <= owed_d;
        end
    end

    // Decode owner into one-hot grant lines.
    always_comb begin
        grant_cpu_o = (kind_q == OWN_CPU);
        for (int i = 0; i < NCH; i++) begin
            grant_dma_o[i] = (kind_q == OWN_DMA) && (idx_q == i[IW-1:0]);
        end
    end
endmodule

// File: rtl/dma_req_arbiter.sv
// Top of the DMA request arbiter.
// Builds one edge flag per channel, a priority picker over the pending and
// enabled channels, and the ownership state machine.
// Assumes: all inputs are synchronous to clk_i.
module dma_req_arbiter #(
    parameter int NCH = 2,
    localparam int IW = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic           clk_i,
    input  logic           rst_ni,
    input  logic [NCH-1:0] req_pin_i,
    input  logic [NCH-1:0] ch_en_i,
    input  logic [NCH-1:0] rise_sel_i,
    input  logic           cpu_done_i,
    input  logic [NCH-1:0] xfer_done_i,
    output logic           grant_cpu_o,
    output logic [NCH-1:0] grant_dma_o,
    output logic [NCH-1:0] req_pend_o
);
    logic [NCH-1:0] start;
    logic [NCH-1:0] elig;
    logic [NCH-1:0] pick_oh;
    logic [IW-1:0]  pick_idx;
    logic           pick_any;

    // One request flag per channel.
    for (genvar g = 0; g < NCH; g++) begin : g_flag
        dmaarb_edge_flag flag_i (
            .clk_i      (clk_i),
            .rst_ni     (rst_ni),
            .pin_i      (req_pin_i[g]),
            .rise_sel_i (rise_sel_i[g]),
            .start_i    (start[g]),
            .flag_o     (req_pend_o[g])
        );
    end

    assign elig = req_pend_o & ch_en_i;

    dmaarb_pick #(.NCH(NCH)) pick_i (
        .elig_i   (elig),
        .any_o    (pick_any),
        .idx_o    (pick_idx),
        .onehot_o (pick_oh)
    );

    dmaarb_owner_fsm #(.NCH(NCH)) fsm_i (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .any_i       (pick_any),
        .idx_i       (pick_idx),
        .onehot_i    (pick_oh),
        .cpu_done_i  (cpu_done_i),
        .xfer_done_i (xfer_done_i),
        .start_o     (start),
        .grant_cpu_o (grant_cpu_o),
        .grant_dma_o (grant_dma_o)
    );
endmodule

// File: rtl/dmaarb_chk.sv
// Property checker for dma_req_arbiter, attached with bind.
// Assumes: done strobes are raised only by the current bus owner.
module dmaarb_chk #(
    parameter int NCH = 2
) (
    input logic           clk_i,
    input logic           rst_ni,
    input logic [NCH-1:0] ch_en_i,
    input logic           cpu_done_i,
    input logic [NCH-1:0] xfer_done_i,
    input logic           grant_cpu_o,
    input logic [NCH-1:0] grant_dma_o,
    input logic [NCH-1:0] req_pend_o
);
    logic owes_q;

    // Tracks whether the CPU still owes its single access after a transfer.
    always_ff @(posedge clk_i) begin
        if (!rst_ni)                              owes_q <= 1'b0;
        else if (|(grant_dma_o & xfer_done_i))    owes_q <= 1'b1;
        else if (grant_cpu_o && cpu_done_i)       owes_q <= 1'b0;
    end

    AST_RESET_STATE: assert property (@(posedge clk_i)
        !rst_ni |=> (grant_cpu_o && grant_dma_o == '0 && req_pend_o == '0)); // R1

    AST_ONE_GRANT: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $countones({grant_dma_o, grant_cpu_o}) == 1); // R10

    AST_CPU_TURN: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (grant_cpu_o && owes_q && !cpu_done_i) |=> grant_cpu_o); // R8

    for (genvar k = 0; k < NCH; k++) begin : g_ch
        AST_GRANT_NEEDS_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
            $rose(grant_dma_o[k]) |-> $past(req_pend_o[k] && ch_en_i[k])); // R4

        AST_REQ_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
            req_pend_o[k] |=> (req_pend_o[k] || $rose(grant_dma_o[k]))); // R6

        AST_DMA_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (grant_dma_o[k] && !xfer_done_i[k]) |=> grant_dma_o[k]); // R7

        AST_DMA_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (grant_dma_o[k] && xfer_done_i[k]) |=> grant_cpu_o); // R7

        if (k > 0) begin : g_prio
            AST_LOW_FIRST: assert property (@(posedge clk_i) disable iff (!rst_ni)
                $rose(grant_dma_o[k]) |-> !$past(|(req_pend_o[k-1:0] & ch_en_i[k-1:0]))); // R5
        end
    end
endmodule

bind dma_req_arbiter dmaarb_chk #(.NCH(NCH)) chk_i (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .ch_en_i     (ch_en_i),
    .cpu_done_i  (cpu_done_i),
    .xfer_done_i (xfer_done_i),
    .grant_cpu_o (grant_cpu_o),
    .grant_dma_o (grant_dma_o),
    .req_pend_o  (req_pend_o)
);

// File: tb/dma_req_arbiter_tb_top.sv
`timescale 1ns/1ps
module dma_req_arbiter_tb_top;
    localparam int NCH = 2;

    logic           clk = 1'b0;
    logic           rst_ni = 1'b0;
    logic [NCH-1:0] req_pin = '0;
    logic [NCH-1:0] en = '0;
    logic [NCH-1:0] rsel = '0;
    logic           cpu_done = 1'b0;
    logic [NCH-1:0] xdone = '0;
    logic           g_cpu;
    logic [NCH-1:0] g_dma;
    logic [NCH-1:0] pend;

    int tests = 0;
    int fails = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    dma_req_arbiter #(.NCH(NCH)) dut_i (
        .clk_i(clk), .rst_ni(rst_ni), .req_pin_i(req_pin), .ch_en_i(en),
        .rise_sel_i(rsel), .cpu_done_i(cpu_done), .xfer_done_i(xdone),
        .grant_cpu_o(g_cpu), .grant_dma_o(g_dma), .req_pend_o(pend)
    );

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Grant word: {dma1, dma0, cpu}
    function automatic logic [7:0] gw();
        return {5'b0, g_dma, g_cpu};
    endfunction

    task automatic do_reset(input logic [NCH-1:0] idle);
        req_pin = idle; en = '0; cpu_done = 1'b0; xdone = '0;
        rst_ni = 1'b0;
        step(); step();
        rst_ni = 1'b1;
    endtask

    initial begin
        #(5.0 * 100000);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("[TB] %0d tests run, %0d failed", tests + 1, fails);
            $finish;
        end
    end

    initial begin
        // R1 reset state
        do_reset('0);
        chk("R1 grants", gw(), 8'b001);
        chk("R1 pend", {6'b0, pend}, 8'h0);

        // R2/R4/R6/R7 sweep: channel, edge select, pin direction
        for (int k = 0; k < NCH; k++) begin
            for (int s = 0; s < 2; s++) begin
                for (int d = 0; d < 2; d++) begin
                    logic hit;
                    logic [NCH-1:0] bit_k;
                    bit_k = '0; bit_k[k] = 1'b1;
                    hit = (d == s);
                    rsel = s[0] ? '1 : '0;
                    do_reset(d[0] ? '0 : '1);
                    req_pin = req_pin ^ bit_k;
                    step();
                    chk("R2 flag after edge", {6'b0, pend}, hit ? {6'b0, bit_k} : 8'h0);
                    step(); step();
                    chk("R4 disabled keeps cpu", gw(), 8'b001);
                    chk("R4 disabled flag held", {6'b0, pend}, hit ? {6'b0, bit_k} : 8'h0);
                    en = bit_k;
                    step();
                    chk("R4 enabled grant", gw(), hit ? {5'b0, bit_k, 1'b0} : 8'b001);
                    chk("R6 flag cleared at start", {6'b0, pend}, 8'h0);
                    if (hit) begin
                        step();
                        chk("R7 hold without done", gw(), {5'b0, bit_k, 1'b0});
                        xdone = bit_k;
                        step();
                        xdone = '0;
                        chk("R7 back to cpu", gw(), 8'b001);
                    end
                end
            end
        end

        // R3 merge of repeated edges while pending
        rsel = '1;
        do_reset('0);
        req_pin[0] = 1'b1; step();
        req_pin[0] = 1'b0; step();
        req_pin[0] = 1'b1; step();
        chk("R3 flag still single", {6'b0, pend}, 8'h01);
        en = 2'b01; step();
        chk("R3 granted", gw(), 8'b010);
        xdone = 2'b01; step(); xdone = '0;
        cpu_done = 1'b1; step(); cpu_done = 1'b0;
        step(); step();
        chk("R3 no second grant", gw(), 8'b001);
        chk("R3 flag empty", {6'b0, pend}, 8'h0);

        // R9/R5/R8 simultaneous edges, both enabled
        do_reset('0);
        en = 2'b11;
        req_pin = 2'b11; step();
        chk("R9 both flags set", {6'b0, pend}, 8'h03);
        chk("R9 cpu still owner", gw(), 8'b001);
        step();
        chk("R5 channel 0 first", gw(), 8'b010);
        chk("R6 only ch0 cleared", {6'b0, pend}, 8'h02);
        xdone = 2'b01; step(); xdone = '0;
        chk("R7 cpu after ch0", gw(), 8'b001);
        step(); step(); step();
        chk("R8 ch1 waits for cpu access", gw(), 8'b001);
        chk("R8 ch1 still pending", {6'b0, pend}, 8'h02);
        cpu_done = 1'b1; step(); cpu_done = 1'b0;
        chk("R8 ch1 after cpu access", gw(), 8'b100);
        chk("R6 ch1 cleared", {6'b0, pend}, 8'h0);
        xdone = 2'b10; step(); xdone = '0;
        chk("R7 cpu after ch1", gw(), 8'b001);

        // R4/R5 only higher index enabled: it is granted despite ch0 pending
        do_reset('1);
        rsel = '0;
        req_pin = 2'b00; step();
        chk("R9 falling both", {6'b0, pend}, 8'h03);
        en = 2'b10; step();
        chk("R4 disabled ch0 skipped", gw(), 8'b100);
        xdone = 2'b10; step(); xdone = '0;
        en = 2'b11;
        step();
        chk("R8 ch0 blocked until cpu access", gw(), 8'b001);
        cpu_done = 1'b1; step(); cpu_done = 1'b0;
        chk("R5 ch0 granted", gw(), 8'b010);

        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule